// File: doc/BRIEF.md
# Register window occupancy controller

This block keeps the bookkeeping of a windowed integer register file. It holds the current window pointer and two occupancy counters: how many further windows can be entered without spilling, and how many can be left without refilling. The pipeline sends it single-cycle command pulses for entering a window, for leaving one (plain or as part of a return), for writing back every resident window, and for software traps. Each pulse moves the pointer and the counters. When a command would run past the resident windows, the block raises a spill, fill or flush request toward the memory side and holds that request until the matching done pulse arrives.

A software trap carries a 7-bit number. That number comes either from an immediate or from the low bits of a register operand. Trap number 3 is handled inside the block as a full flush. Every other number leaves the block as a dispatch vector equal to the number plus 256. The register file itself, the spill and fill memory traffic, and the address arithmetic that goes with entering or leaving a window all sit outside the block.

Top module: `rwin_ctrl`

## Requirements
- R1: After reset the window pointer is 0, the save counter is NWINDOWS-2, the restore counter is 0, and no request, busy or trap output is active.
- R2: A save with a nonzero save counter updates state in the next cycle: the pointer becomes (pointer+1) mod NWINDOWS, the save counter drops by one and the restore counter rises by one. The two counters always sum to NWINDOWS-2.
- R3: A save with a zero save counter raises spill_req_o and busy_o in the next cycle and leaves the counters unchanged. In the cycle after spill_done_i, the save counter equals the old restore counter minus one, the restore counter is 1 and the pointer has advanced by one modulo NWINDOWS.
- R4: A restore or a return with a nonzero restore counter updates state in the next cycle: the save counter rises by one, the restore counter drops by one and the pointer becomes (pointer+NWINDOWS-1) mod NWINDOWS.
- R5: A restore or a return with a zero restore counter raises fill_req_o and busy_o. In the cycle after fill_done_i, the pointer has moved down by one modulo NWINDOWS and the restore counter stays 0. The save counter rises by one only if it was below NWINDOWS-2.
- R6: A flush command raises flush_req_o and busy_o. In the cycle after flush_done_i, the save counter is NWINDOWS-2 and the restore counter is 0, and the pointer is unchanged.
- R7: The trap number is trap_imm_i when trap_imm_sel_i is 1, and bits [6:0] of trap_reg_i when trap_imm_sel_i is 0.
- R8: A trap whose number is 3 runs the flush sequence of R6 and produces no dispatch vector.
- R9: A trap with any other number drives trap_vld_o high for exactly one cycle, in the cycle after the command, with trap_vec_o equal to 256 plus the number.
- R10: While busy_o is high, command pulses have no effect and a done pulse for a request type other than the pending one has no effect. At most one request output is high at a time.
- R11: When several command pulses arrive together, only one of them acts. Save wins over restore, restore over return, return over flush, and flush over trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| save_i | input | 1 | Enter-window command pulse |
| restore_i | input | 1 | Leave-window command pulse |
| return_i | input | 1 | Leave-window command pulse issued by a return |
| flush_i | input | 1 | Write-back-all-windows command pulse |
| trap_i | input | 1 | Software trap command pulse |
| trap_imm_sel_i | input | 1 | 1: trap number from trap_imm_i; 0: from trap_reg_i |
| trap_imm_i | input | 7 | Immediate trap number |
| trap_reg_i | input | REG_W | Register operand; bits [6:0] form the trap number |
| spill_req_o | output | 1 | Spill of the current window requested |
| spill_done_i | input | 1 | Spill finished |
| fill_req_o | output | 1 | Fill of the previous window requested |
| fill_done_i | input | 1 | Fill finished |
| flush_req_o | output | 1 | Write-back of all resident windows requested |
| flush_done_i | input | 1 | Flush finished |
| busy_o | output | 1 | A request is outstanding; commands are ignored |
| cwp_o | output | 5 | Current window pointer |
| cansave_o | output | 5 | Save counter |
| canrestore_o | output | 5 | Restore counter |
| trap_vld_o | output | 1 | Trap dispatch pulse |
| trap_vec_o | output | 9 | Trap dispatch vector, valid with trap_vld_o |

## Verification
The bench builds the block with NWINDOWS=6 and REG_W=32. With six windows, the save counter empties after four saves and the pointer wraps after six moves. Long runs of saves and restores therefore cross both the spill path and the pointer wrap many times, in both directions. A 32-bit register operand with upper bits set shows that only its low seven bits pick the trap number. The run also confirms that trap number 3 coming from the register path is taken as a flush.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int unsigned PTR_W      = 5;
  localparam int unsigned TNUM_W     = 7;
  localparam int unsigned VEC_W      = 9;
  localparam logic [TNUM_W-1:0] TNUM_FLUSH = 7'd3;
  localparam logic [VEC_W-1:0]  VEC_BASE   = 9'd256;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_SAVE, CMD_RESTORE, CMD_FLUSH, CMD_TRAP
  } rwin_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_SPILL, ST_FILL, ST_FLUSH
  } rwin_state_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_SAVE, OP_SPILL_SAVE, OP_RESTORE, OP_FILL_RESTORE, OP_FLUSH
  } rwin_op_e;
endpackage

// File: rtl/rwin_cmd_decode.sv
module rwin_cmd_decode
  import rwin_pkg::*;
#(
  parameter int unsigned REG_W = 64
) (
  input  logic              save_i,
  input  logic              restore_i,
  input  logic              return_i,
  input  logic              flush_i,
  input  logic              trap_i,
  input  logic              trap_imm_sel_i,
  input  logic [TNUM_W-1:0] trap_imm_i,
  input  logic [REG_W-1:0]  trap_reg_i,
  output rwin_cmd_e         cmd_o,
  output logic [TNUM_W-1:0] trap_num_o
);
  assign trap_num_o = trap_imm_sel_i ? trap_imm_i : trap_reg_i[TNUM_W-1:0];

  // fixed priority; return shares the restore path, trap 3 folds into flush
  always_comb begin
    cmd_o = CMD_NONE;
    if (save_i)                                  cmd_o = CMD_SAVE;
    else if (restore_i || return_i)              cmd_o = CMD_RESTORE;
    else if (flush_i)                            cmd_o = CMD_FLUSH;
    else if (trap_i && trap_num_o == TNUM_FLUSH) cmd_o = CMD_FLUSH;
    else if (trap_i)                             cmd_o = CMD_TRAP;
  end
endmodule

// File: rtl/rwin_seq.sv
module rwin_seq
  import rwin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rwin_cmd_e         cmd_i,
  input  logic [TNUM_W-1:0] trap_num_i,
  input  logic              cs_zero_i,
  input  logic              cr_zero_i,
  input  logic              spill_done_i,
  input  logic              fill_done_i,
  input  logic              flush_done_i,
  output rwin_op_e          op_o,
  output logic              spill_req_o,
  output logic              fill_req_o,
  output logic              flush_req_o,
  output logic              busy_o,
  output logic              trap_vld_o,
  output logic [VEC_W-1:0]  trap_vec_o
);
  rwin_state_e state_q, state_d;
  logic        trap_fire;

  always_comb begin
    state_d   = state_q;
    op_o      = OP_NONE;
    trap_fire = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        unique case (cmd_i)
          CMD_SAVE:    if (cs_zero_i) state_d = ST_SPILL; else op_o = OP_SAVE;
          CMD_RESTORE: if (cr_zero_i) state_d = ST_FILL;  else op_o = OP_RESTORE;
          CMD_FLUSH:   state_d = ST_FLUSH;
          CMD_TRAP:    trap_fire = 1'b1;
          default:     ;
        endcase
      end
      ST_SPILL: if (spill_done_i) begin op_o = OP_SPILL_SAVE;   state_d = ST_IDLE; end
      ST_FILL:  if (fill_done_i)  begin op_o = OP_FILL_RESTORE; state_d = ST_IDLE; end
      ST_FLUSH: if (flush_done_i) begin op_o = OP_FLUSH;        state_d = ST_IDLE; end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      trap_vld_o <= 1'b0;
      trap_vec_o <= '0;
    end else begin
      state_q    <= state_d;
      trap_vld_o <= trap_fire;
      if (trap_fire) trap_vec_o <= VEC_BASE + VEC_W'(trap_num_i);
    end
  end

  assign spill_req_o = (state_q == ST_SPILL);
  assign fill_req_o  = (state_q == ST_FILL);
  assign flush_req_o = (state_q == ST_FLUSH);
  assign busy_o      = (state_q != ST_IDLE);

  p_one_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({spill_req_o, fill_req_o, flush_req_o}));
  p_spill_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spill_req_o && !spill_done_i) |=> spill_req_o);
  p_fill_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !fill_done_i) |=> fill_req_o);
  p_trap_vec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_vld_o |-> (trap_vec_o >= VEC_BASE && trap_vec_o != VEC_BASE + 9'd3));
  p_trap_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_vld_o |-> !busy_o);
endmodule

// File: rtl/rwin_window_state.sv
module rwin_window_state
  import rwin_pkg::*;
#(
  parameter int unsigned NWINDOWS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rwin_op_e         op_i,
  output logic [PTR_W-1:0] cwp_o,
  output logic [PTR_W-1:0] cansave_o,
  output logic [PTR_W-1:0] canrestore_o
);
  localparam logic [PTR_W-1:0] LAST_WIN = PTR_W'(NWINDOWS - 1);
  localparam logic [PTR_W-1:0] CS_FULL  = PTR_W'(NWINDOWS - 2);

  logic [PTR_W-1:0] cwp_q, cs_q, cr_q;
  logic [PTR_W-1:0] cwp_d, cs_d, cr_d;
  logic [PTR_W-1:0] cwp_up, cwp_dn;

  assign cwp_up = (cwp_q == LAST_WIN) ? '0 : cwp_q + 1'b1;
  assign cwp_dn = (cwp_q == '0) ? LAST_WIN : cwp_q - 1'b1;

  always_comb begin
    cwp_d = cwp_q;
    cs_d  = cs_q;
    cr_d  = cr_q;
    unique case (op_i)
      OP_SAVE:         begin cwp_d = cwp_up; cs_d = cs_q - 1'b1; cr_d = cr_q + 1'b1; end
      OP_SPILL_SAVE:   begin cwp_d = cwp_up; cs_d = cr_q - 1'b1; cr_d = PTR_W'(1); end
      OP_RESTORE:      begin cwp_d = cwp_dn; cs_d = cs_q + 1'b1; cr_d = cr_q - 1'b1; end
      OP_FILL_RESTORE: begin cwp_d = cwp_dn; if (cs_q < CS_FULL) cs_d = cs_q + 1'b1; end
      OP_FLUSH:        begin cs_d = CS_FULL; cr_d = '0; end
      default:         ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      cs_q  <= CS_FULL;
      cr_q  <= '0;
    end else begin
      cwp_q <= cwp_d;
      cs_q  <= cs_d;
      cr_q  <= cr_d;
    end
  end

  assign cwp_o        = cwp_q;
  assign cansave_o    = cs_q;
  assign canrestore_o = cr_q;

  p_cnt_sum_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cs_q) + int'(cr_q)) == NWINDOWS - 2);
  p_ptr_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cwp_q) < NWINDOWS);
  p_restore_cnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_RESTORE) |=> (cr_q == $past(cr_q) - 1'b1));
  p_fill_cr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_FILL_RESTORE) |=> (cr_q == '0));
  p_flush_ptr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_FLUSH) |=> $stable(cwp_q));
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_NONE) |=> ($stable(cwp_q) && $stable(cs_q) && $stable(cr_q)));
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
  import rwin_pkg::*;
#(
  parameter int unsigned NWINDOWS = 8,
  parameter int unsigned REG_W    = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              save_i,
  input  logic              restore_i,
  input  logic              return_i,
  input  logic              flush_i,
  input  logic              trap_i,
  input  logic              trap_imm_sel_i,
  input  logic [6:0]        trap_imm_i,
  input  logic [REG_W-1:0]  trap_reg_i,
  output logic              spill_req_o,
  input  logic              spill_done_i,
  output logic              fill_req_o,
  input  logic              fill_done_i,
  output logic              flush_req_o,
  input  logic              flush_done_i,
  output logic              busy_o,
  output logic [4:0]        cwp_o,
  output logic [4:0]        cansave_o,
  output logic [4:0]        canrestore_o,
  output logic              trap_vld_o,
  output logic [8:0]        trap_vec_o
);
  rwin_cmd_e         cmd;
  rwin_op_e          op;
  logic [TNUM_W-1:0] trap_num;

  rwin_cmd_decode #(.REG_W(REG_W)) u_dec (
    .save_i, .restore_i, .return_i, .flush_i, .trap_i,
    .trap_imm_sel_i, .trap_imm_i, .trap_reg_i,
    .cmd_o(cmd), .trap_num_o(trap_num)
  );

  rwin_seq u_seq (
    .clk_i, .rst_ni,
    .cmd_i(cmd), .trap_num_i(trap_num),
    .cs_zero_i(cansave_o == '0), .cr_zero_i(canrestore_o == '0),
    .spill_done_i, .fill_done_i, .flush_done_i,
    .op_o(op),
    .spill_req_o, .fill_req_o, .flush_req_o, .busy_o,
    .trap_vld_o, .trap_vec_o
  );

  rwin_window_state #(.NWINDOWS(NWINDOWS)) u_win (
    .clk_i, .rst_ni, .op_i(op),
    .cwp_o, .cansave_o, .canrestore_o
  );

  p_busy_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !spill_done_i && !fill_done_i && !flush_done_i)
      |=> ($stable(cwp_o) && $stable(cansave_o) && busy_o));
  p_trap_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !trap_vld_o);
endmodule

// File: tb/rwin_ctrl_bench.sv
module rwin_ctrl_bench;
  localparam int NW = 6;
  localparam int RW = 32;

  typedef struct packed {
    logic sv, rs, rt, fl, tr, isel;
    logic [6:0] imm;
    logic [RW-1:0] rg;
    logic spd, fld, fsd;
  } stim_t;

  typedef struct packed {
    logic [4:0] cwp, cs, cr;
    logic busy, spill, fill, flush, tvld;
    logic [8:0] vec;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  stim_t s_in = '0;
  logic spill_req, fill_req, flush_req, busy, trap_vld;
  logic [4:0] cwp, cs, cr;
  logic [8:0] vec;

  always #2.5 clk = ~clk;

  rwin_ctrl #(.NWINDOWS(NW), .REG_W(RW)) u_rwin_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .save_i(s_in.sv), .restore_i(s_in.rs), .return_i(s_in.rt),
    .flush_i(s_in.fl), .trap_i(s_in.tr), .trap_imm_sel_i(s_in.isel),
    .trap_imm_i(s_in.imm), .trap_reg_i(s_in.rg),
    .spill_req_o(spill_req), .spill_done_i(s_in.spd),
    .fill_req_o(fill_req), .fill_done_i(s_in.fld),
    .flush_req_o(flush_req), .flush_done_i(s_in.fsd),
    .busy_o(busy), .cwp_o(cwp), .cansave_o(cs), .canrestore_o(cr),
    .trap_vld_o(trap_vld), .trap_vec_o(vec)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  // reference model state
  int m_cwp = 0, m_cs = NW - 2, m_cr = 0, m_pend = 0; // pend: 0 none,1 spill,2 fill,3 flush

  function automatic exp_t model(stim_t s);
    exp_t e;
    int tn;
    logic tv = 1'b0;
    int v = 0;
    if (m_pend != 0) begin
      if (m_pend == 1 && s.spd) begin
        m_cs = m_cr - 1; m_cr = 1; m_cwp = (m_cwp + 1) % NW; m_pend = 0;
      end else if (m_pend == 2 && s.fld) begin
        if (m_cs < NW - 2) m_cs++;
        m_cwp = (m_cwp + NW - 1) % NW; m_pend = 0;
      end else if (m_pend == 3 && s.fsd) begin
        m_cs = NW - 2; m_cr = 0; m_pend = 0;
      end
    end else begin
      tn = s.isel ? int'(s.imm) : int'(s.rg[6:0]);
      if (s.sv) begin
        if (m_cs == 0) m_pend = 1;
        else begin m_cs--; m_cr++; m_cwp = (m_cwp + 1) % NW; end
      end else if (s.rs || s.rt) begin
        if (m_cr == 0) m_pend = 2;
        else begin m_cs++; m_cr--; m_cwp = (m_cwp + NW - 1) % NW; end
      end else if (s.fl || (s.tr && tn == 3)) m_pend = 3;
      else if (s.tr) begin tv = 1'b1; v = 256 + tn; end
    end
    e.cwp = 5'(m_cwp); e.cs = 5'(m_cs); e.cr = 5'(m_cr);
    e.busy = (m_pend != 0); e.spill = (m_pend == 1);
    e.fill = (m_pend == 2); e.flush = (m_pend == 3);
    e.tvld = tv; e.vec = 9'(v);
    return e;
  endfunction

  // driver: one cycle of stimulus, expected result pushed for the monitor
  task automatic step(stim_t s, string tag);
    s_in = s;
    @(negedge clk);
    s_in = '0;
    exp_q.push_back(model(s));
    tag_q.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = '{cwp, cs, cr, busy, spill_req, fill_req, flush_req, trap_vld, vec};
        if (!e.tvld) a.vec = e.vec;
        n_run++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s: got cwp=%0d cs=%0d cr=%0d busy=%b sp=%b fi=%b fl=%b tv=%b vec=%0d exp cwp=%0d cs=%0d cr=%0d busy=%b sp=%b fi=%b fl=%b tv=%b vec=%0d",
                   t, a.cwp, a.cs, a.cr, a.busy, a.spill, a.fill, a.flush, a.tvld, a.vec,
                   e.cwp, e.cs, e.cr, e.busy, e.spill, e.fill, e.flush, e.tvld, e.vec);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    stim_t s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    s = '0; step(s, "R1");                                   // reset state
    s = '0; s.rs = 1; step(s, "R5");                         // fill, counter at ceiling
    s = '0; step(s, "R5");
    s = '0; s.fld = 1; step(s, "R5");                        // cwp 0 -> 5
    for (int i = 0; i < 4; i++) begin s = '0; s.sv = 1; step(s, "R2"); end
    s = '0; s.sv = 1; step(s, "R3");                         // spill
    s = '0; s.rs = 1; step(s, "R10");                        // ignored while busy
    s = '0; s.fld = 1; step(s, "R10");                       // wrong done ignored
    s = '0; s.spd = 1; step(s, "R3");
    s = '0; s.rt = 1; step(s, "R4");
    s = '0; s.rs = 1; step(s, "R5");
    s = '0; s.fld = 1; step(s, "R5");
    s = '0; s.sv = 1; step(s, "R2");
    s = '0; s.fl = 1; step(s, "R6");
    s = '0; s.spd = 1; s.fld = 1; step(s, "R10");
    s = '0; s.fsd = 1; step(s, "R6");
    s = '0; s.sv = 1; step(s, "R2");
    s = '0; s.tr = 1; s.rg = 32'hFFFF_FF83; step(s, "R8");   // reg number 3
    s = '0; s.fsd = 1; step(s, "R8");
    s = '0; s.tr = 1; s.isel = 1; s.imm = 7'd16; s.rg = 32'd3; step(s, "R7");
    s = '0; s.tr = 1; s.imm = 7'd3; s.rg = 32'hFFFF_FF85; step(s, "R7");
    s = '0; step(s, "R9");                                   // pulse ends
    s = '0; s.tr = 1; s.isel = 1; s.imm = 7'd127; step(s, "R9");
    s = '0; s.tr = 1; s.isel = 1; s.imm = 7'd0; step(s, "R9");
    s = '0; s.tr = 1; s.isel = 1; s.imm = 7'd3; step(s, "R8");
    s = '0; s.fsd = 1; step(s, "R8");
    s = '0; s.sv = 1; s.rs = 1; step(s, "R11");
    s = '0; s.rs = 1; s.fl = 1; step(s, "R11");
    s = '0; s.rt = 1; s.tr = 1; s.isel = 1; s.imm = 7'd9; step(s, "R11");
    s = '0; s.fl = 1; s.tr = 1; s.isel = 1; s.imm = 7'd5; step(s, "R11");
    s = '0; s.fsd = 1; step(s, "R6");
    for (int i = 0; i < 14; i++) begin
      s = '0; s.sv = 1; step(s, "R3");
      if (m_pend == 1) begin s = '0; s.spd = 1; step(s, "R3"); end
    end
    for (int i = 0; i < 14; i++) begin
      s = '0; s.rt = (i % 2 == 0); s.rs = (i % 2 != 0); step(s, "R4");
      if (m_pend == 2) begin s = '0; s.fld = 1; step(s, "R5"); end
    end
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule